// File: doc/BRIEF.md
# Registered Read-Only Byte Store with Strappable Output Enable

This block is a one-time-writable byte store of 64K locations. Each read goes through an edge-triggered 8-bit output register, and the result reaches a tri-state output port. A single active-low enable controls the output drivers. A mode strap decides how that enable acts. In combinational mode it switches the drivers at once. In clocked mode it is captured on each rising clock edge and only takes effect after that edge.

The storage is arranged as 512 lines of 1024 cells. The upper nine address bits pick a line. The lower seven bits steer eight independent 1-of-128 selectors, one per data bit. A byte-wide programming port fills the array while reads are idle. It can only turn ones into zeros, which models one-way programming from an erased all-ones state. Reset returns every location to the erased state, clears the output register and latches the mode strap.

Top module: `rom_registered`

## Requirements
- R1: While reset is low, the output register holds 0x00 and the clocked-mode enable flop holds the disabled state. Right after reset is released, before any clock edge, `q` shows 0x00 in combinational mode with `en_n` low, and is high impedance in clocked mode.
- R2: After reset, every location reads as 0xFF until it is programmed.
- R3: A clock edge with `pgm_stb` high sets the byte at `pgm_addr` to its old value AND `pgm_data`. Bits can be cleared but never set.
- R4: The byte at the address present on a rising edge appears on `q` just after that edge. It stays there, even if the address changes, until the next rising edge.
- R5: The output register loads on every rising edge whatever the level of `en_n`. A byte captured while the drivers were off appears as soon as they are turned on.
- R6: In combinational mode (strap 0), `q` is high impedance whenever `en_n` is 1 and is driven whenever `en_n` is 0, with no clock edge needed.
- R7: In clocked mode (strap 1), a change on `en_n` affects the drivers only after the next rising edge. `en_n` sampled low enables them and `en_n` sampled high disables them.
- R8: `sync_mode` is sampled only while reset is low. Changes on it after reset is released have no effect on enable timing.
- R9: Address bits 15..7 select the line and bits 6..0 select the column. Addresses that differ only in line bits, or only in column bits, hold independent bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | Enable-timing strap: 0 combinational, 1 clocked; sampled during reset |
| addr | input | 16 | Read address |
| en_n | input | 1 | Active-low output enable |
| q | output | 8 | Tri-state read data |
| pgm_stb | input | 1 | Program strobe; one byte written per edge while high |
| pgm_addr | input | 16 | Program address |
| pgm_data | input | 8 | Program data, ANDed into the stored byte |

## Verification
A wrong line or column decode shows up as a programmed byte that reads back under a neighbouring address, or as 0xFF where data was written. This is visible one edge after the address is applied. A broken programming path shows up as bits coming back set after a second, narrower write. A fault in the enable path shows at the ports within one edge. Either `q` floats when it should be driven, or it is driven when it should float. In clocked mode the change happens one cycle early, and in combinational mode it fails to happen before the edge. A mode flop that follows the strap after reset gives combinational timing inside a clocked-mode session.

// File: rtl/rom_pkg.sv
package rom_pkg;
   localparam int ROM_ADDR_W = 16;
   localparam int ROM_DATA_W = 8;
   localparam int ROM_COL_W  = 7;

   typedef enum logic {
      OE_COMB  = 1'b0,
      OE_CLKED = 1'b1
   } oe_mode_e;
endpackage

// File: rtl/rom_array.sv
module rom_array #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int COL_W  = 7,
   localparam int ROW_W  = ADDR_W - COL_W,
   localparam int ROWS   = 2 ** ROW_W,
   localparam int COLS   = 2 ** COL_W,
   localparam int LINE_W = DATA_W * COLS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ROW_W-1:0]  rd_row,
   output logic [LINE_W-1:0] rd_line,
   input  logic              pgm_stb,
   input  logic [ADDR_W-1:0] pgm_addr,
   input  logic [DATA_W-1:0] pgm_data
);
   if (COL_W < 1 || COL_W >= ADDR_W) begin : g_bad_split
      $error("rom_array: COL_W must lie between 1 and ADDR_W-1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("rom_array: DATA_W must be positive");
   end

   logic [LINE_W-1:0] cells [ROWS];
   logic [ROWS-1:0]   blank;

   logic [ROW_W-1:0]  w_row;
   logic [COL_W-1:0]  w_col;
   logic [LINE_W-1:0] w_cur;
   logic [LINE_W-1:0] w_nxt;

   assign w_row = pgm_addr[ADDR_W-1:COL_W];
   assign w_col = pgm_addr[COL_W-1:0];
   assign w_cur = blank[w_row] ? {LINE_W{1'b1}} : cells[w_row];

   always_comb begin
      w_nxt = w_cur;
      for (int b = 0; b < DATA_W; b++) begin
         w_nxt[b*COLS + int'(w_col)] = w_cur[b*COLS + int'(w_col)] & pgm_data[b];
      end
   end

   always_ff @(posedge clk) begin
      if (pgm_stb) cells[w_row] <= w_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       blank <= '1;
      else if (pgm_stb) blank[w_row] <= 1'b0;
   end

   assign rd_line = blank[rd_row] ? {LINE_W{1'b1}} : cells[rd_row];

   // checker state: remember the last write and look at the stored byte
   logic              chk_vld;
   logic [ROW_W-1:0]  chk_row;
   logic [COL_W-1:0]  chk_col;
   logic [DATA_W-1:0] chk_data;
   logic [DATA_W-1:0] chk_byte;
   logic [LINE_W-1:0] chk_line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_vld  <= 1'b0;
         chk_row  <= '0;
         chk_col  <= '0;
         chk_data <= '0;
      end else begin
         chk_vld  <= pgm_stb;
         chk_row  <= w_row;
         chk_col  <= w_col;
         chk_data <= pgm_data;
      end
   end

   assign chk_line = blank[chk_row] ? {LINE_W{1'b1}} : cells[chk_row];
   always_comb begin
      for (int b = 0; b < DATA_W; b++) chk_byte[b] = chk_line[b*COLS + int'(chk_col)];
   end

   // R3
   pgm_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_vld |-> ((chk_byte & ~chk_data) == '0));
endmodule

// File: rtl/rom_colmux.sv
module rom_colmux #(
   parameter int DATA_W = 8,
   parameter int COL_W  = 7,
   localparam int COLS   = 2 ** COL_W,
   localparam int LINE_W = DATA_W * COLS
) (
   input  logic [LINE_W-1:0] line,
   input  logic [COL_W-1:0]  col,
   output logic [DATA_W-1:0] word
);
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      logic [COLS-1:0] group;
      assign group   = line[b*COLS +: COLS];
      assign word[b] = group[col];
   end
endmodule

// File: rtl/rom_oe_ctl.sv
module rom_oe_ctl
   import rom_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  oe_mode_e mode,
   input  logic     en_n,
   output logic     drive
);
   logic en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= ~en_n;
   end

   assign drive = (mode == OE_CLKED) ? en_q : ~en_n;

   // R7
   clked_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == OE_CLKED && !en_n) |=> (drive || mode != OE_CLKED));
   // R7
   clked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == OE_CLKED && en_n) |=> (!drive || mode != OE_CLKED));
endmodule

// File: rtl/rom_registered.sv
module rom_registered
   import rom_pkg::*;
#(
   parameter int ADDR_W = ROM_ADDR_W,
   parameter int DATA_W = ROM_DATA_W,
   parameter int COL_W  = ROM_COL_W,
   localparam int ROW_W  = ADDR_W - COL_W,
   localparam int LINE_W = DATA_W * (2 ** COL_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic              en_n,
   output logic [DATA_W-1:0] q,
   input  logic              pgm_stb,
   input  logic [ADDR_W-1:0] pgm_addr,
   input  logic [DATA_W-1:0] pgm_data
);
   logic [LINE_W-1:0] line_w;
   logic [DATA_W-1:0] word_w;
   logic [DATA_W-1:0] dout_q;
   oe_mode_e          mode_q;
   logic              drive_w;

   rom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W)) i_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_row   (addr[ADDR_W-1:COL_W]),
      .rd_line  (line_w),
      .pgm_stb  (pgm_stb),
      .pgm_addr (pgm_addr),
      .pgm_data (pgm_data)
   );

   rom_colmux #(.DATA_W(DATA_W), .COL_W(COL_W)) i_colmux (
      .line (line_w),
      .col  (addr[COL_W-1:0]),
      .word (word_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= oe_mode_e'(sync_mode);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout_q <= '0;
      else        dout_q <= word_w;
   end

   rom_oe_ctl i_oe (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode_q),
      .en_n  (en_n),
      .drive (drive_w)
   );

   assign q = drive_w ? dout_q : {DATA_W{1'bz}};

   // R6
   comb_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == OE_COMB && en_n) |-> !drive_w);
   // R8
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(mode_q));
endmodule

// File: tb/test_rom_registered.sv
module test_rom_registered;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sync_mode = 1'b0;
   logic [15:0] addr = '0;
   logic        en_n = 1'b1;
   wire  [7:0]  q;
   logic        pgm_stb = 1'b0;
   logic [15:0] pgm_addr = '0;
   logic [7:0]  pgm_data = '0;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [7:0] model [int];

   always #2 clk = ~clk;

   rom_registered i_rom_registered (
      .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .addr(addr), .en_n(en_n),
      .q(q), .pgm_stb(pgm_stb), .pgm_addr(pgm_addr), .pgm_data(pgm_data)
   );

   function automatic logic [7:0] pat(input logic [15:0] a);
      return a[15:8] ^ a[7:0] ^ 8'h5A;
   endfunction

   function automatic logic [7:0] expv(input logic [15:0] a);
      return model.exists(int'(a)) ? model[int'(a)] : 8'hFF;
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic m, input logic en);
      @(negedge clk);
      rst_n = 1'b0; sync_mode = m; en_n = en;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model.delete();
      #1;
   endtask

   task automatic prog(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      pgm_stb = 1'b1; pgm_addr = a; pgm_data = d;
      @(negedge clk);
      pgm_stb = 1'b0;
      model[int'(a)] = expv(a) & d;
   endtask

   task automatic rd(input string tag, input logic [15:0] a);
      @(negedge clk);
      addr = a;
      @(posedge clk);
      #1 check(tag, q, expv(a));
   endtask

   task automatic load_pattern();
      prog(16'h0000, pat(16'h0000));
      prog(16'h0001, pat(16'h0001));
      prog(16'h007F, pat(16'h007F));
      prog(16'h0080, pat(16'h0080));
      prog(16'h1234, pat(16'h1234));
      prog(16'hFFFF, pat(16'hFFFF));
   endtask

   task automatic t_reset_comb();
      do_reset(1'b0, 1'b0);
      check("R1 reset value driven in comb mode", q, 8'h00);
      rd("R2 blank location", 16'h4321);
      rd("R2 blank location high", 16'hFFFE);
   endtask

   task automatic t_program();
      load_pattern();
      rd("R9 addr 0000", 16'h0000);
      rd("R9 column neighbour 0001", 16'h0001);
      rd("R9 column edge 007F", 16'h007F);
      rd("R9 line neighbour 0080", 16'h0080);
      rd("R3 addr 1234", 16'h1234);
      rd("R9 top address FFFF", 16'hFFFF);
      rd("R9 untouched 0100", 16'h0100);
      prog(16'h1234, 8'h0F);
      rd("R3 second write only clears", 16'h1234);
      prog(16'h1234, 8'hFF);
      rd("R3 ones cannot be restored", 16'h1234);
   endtask

   task automatic t_latency();
      @(negedge clk); en_n = 1'b0; addr = 16'h0080;
      @(posedge clk); #1 check("R4 data after edge", q, expv(16'h0080));
      @(negedge clk); addr = 16'hFFFF;
      #1 check("R4 held until next edge", q, expv(16'h0080));
      @(posedge clk); #1 check("R4 new data after edge", q, expv(16'hFFFF));
   endtask

   task automatic t_comb_oe();
      @(negedge clk); en_n = 1'b1; addr = 16'h0001;
      #1 check("R6 floats at once", q, 8'hzz);
      @(posedge clk); #1 check("R6 floats across edge", q, 8'hzz);
      @(negedge clk); en_n = 1'b0;
      #1 check("R5 R6 byte loaded while disabled", q, expv(16'h0001));
   endtask

   task automatic t_reset_clked();
      do_reset(1'b1, 1'b0);
      check("R1 clocked mode floats after reset", q, 8'hzz);
      load_pattern();
      @(negedge clk); sync_mode = 1'b0;
   endtask

   task automatic t_clked_oe();
      @(negedge clk); en_n = 1'b1; addr = 16'h007F;
      @(posedge clk); #1 check("R7 disabled after edge", q, 8'hzz);
      @(negedge clk); en_n = 1'b0;
      #1 check("R7 enable waits for edge", q, 8'hzz);
      @(posedge clk); #1 check("R7 enabled after edge", q, expv(16'h007F));
      @(negedge clk); en_n = 1'b1;
      #1 check("R7 R8 disable waits for edge", q, expv(16'h007F));
      @(posedge clk); #1 check("R7 disabled after edge", q, 8'hzz);
   endtask

   initial begin
      t_reset_comb();
      t_program();
      t_latency();
      t_comb_oe();
      t_reset_clked();
      t_clked_oe();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule